// File: doc/BRIEF.md
# Split-Tenure Bus Master Controller

This block is the master-side sequencer for a shared system bus on which the address phase and the data phase are two separate tenures. Each tenure has its own grant, and each has its own busy line that other masters also drive. An internal initiator posts transfer requests as single-cycle pulses. The block counts the outstanding requests and raises the bus request. It waits until it holds the address grant and no other master holds address-busy. It then opens the address tenure with a one-cycle transfer-start strobe and keeps address-busy active until a slave acknowledges the address.

When the address is acknowledged, a retry can still arrive in that cycle or in the next one. If a retry arrives, the transaction goes back into the request count and is started again later. If no retry arrives, the data tenure is armed. It waits for the data grant and for data-busy to be idle, and then holds data-busy until the transfer acknowledge. A one-cycle completion pulse goes back to the initiator for each transaction that finishes.

Every bus control line is active-low, so 0 means asserted. The lines the block can float come with a separate output enable. Each busy line is driven high for exactly one cycle before its enable is dropped.

Top module: `split_bus_master`

## Requirements
- R1: While reset is active and just after it, br_no, ts_no, abb_no and dbb_no are 1, ts_oe_o, abb_oe_o and dbb_oe_o are 0, and done_o is 0.
- R2: br_no is 0 while a posted transaction waits for its address tenure, and it stays 0 through the transfer-start cycle.
- R3: ts_no goes to 0 only in a cycle that follows a clock edge at which bg_ni was 0 and abb_ni was 1. A low abb_ni holds the start off even while the grant is present.
- R4: ts_no is 0 for exactly one cycle. In that cycle abb_oe_o and ts_oe_o are 1 and abb_no is 0. abb_no stays 0 with its enable on in every later cycle until aack_ni is sampled 0.
- R5: In the cycle after aack_ni is sampled 0, abb_no is driven 1 with abb_oe_o still 1. In the following cycle abb_oe_o is 0.
- R6: If artry_ni is sampled 0 at the edge that samples aack_ni 0, or at the edge after it, the transaction is requeued. It gets a further transfer-start later, and that retried attempt gets no data tenure.
- R7: A data tenure (dbb_oe_o 1, dbb_no 0) begins only after an address tenure that finished without retry, and only after an edge at which dbg_ni was 0 and dbb_ni was 1.
- R8: dbb_no stays 0 until ta_ni is sampled 0. In the next cycle dbb_no is driven 1 with dbb_oe_o 1, and in the cycle after that dbb_oe_o is 0.
- R9: done_o pulses for one cycle, in the cycle after ta_ni is sampled 0. There is exactly one pulse per posted request, in posting order.
- R10: In the cycle after transfer-start, br_no is 1 if no other request is outstanding and 0 if another one is.
- R11: A new transfer-start never happens while the block's own data tenure is armed or active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle pulse that posts a transfer |
| done_o | output | 1 | One-cycle completion pulse |
| br_no | output | 1 | Bus request, active low |
| bg_ni | input | 1 | Address bus grant, active low |
| abb_ni | input | 1 | Address-busy sensed from other masters, active low |
| abb_no | output | 1 | Address-busy drive value, active low |
| abb_oe_o | output | 1 | Address-busy output enable |
| ts_no | output | 1 | Transfer-start strobe, active low |
| ts_oe_o | output | 1 | Transfer-start output enable |
| aack_ni | input | 1 | Address acknowledge, active low |
| artry_ni | input | 1 | Address retry, active low |
| dbg_ni | input | 1 | Data bus grant, active low |
| dbb_ni | input | 1 | Data-busy sensed from other masters, active low |
| dbb_no | output | 1 | Data-busy drive value, active low |
| dbb_oe_o | output | 1 | Data-busy output enable |
| ta_ni | input | 1 | Transfer acknowledge, active low |

## Verification
A sequencer stuck in the wrong state shows up at the pins within one cycle. Possible symptoms are a transfer-start without a matching address-busy drive, a busy line that stays driven low after its acknowledge, or an enable that stays on past the one-cycle high drive. A request counter that is off by one takes longer to show. It appears as a wrong bus request level in the cycle after transfer-start, or as a missing or extra completion pulse once the scoreboard drains. A lost retry flag shows as a data tenure for an attempt that should have been retried, one to three cycles after the acknowledge.

// File: rtl/split_bus_pkg.sv
package split_bus_pkg;
  typedef enum logic [2:0] {
    A_IDLE,
    A_REQ,
    A_TS,
    A_BUSY,
    A_REL
  } addr_st_e;

  typedef enum logic [1:0] {
    D_IDLE,
    D_WAIT,
    D_BUSY,
    D_REL
  } data_st_e;
endpackage

// File: rtl/sbm_req_queue.sv
module sbm_req_queue #(
  parameter int CNT_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic requeue_i,
  input  logic pop_i,
  output logic nonempty_o
);
  localparam logic [CNT_W:0] CntMax = (CNT_W+1)'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum = {1'b0, cnt_q} + {{CNT_W{1'b0}}, push_i} + {{CNT_W{1'b0}}, requeue_i}
        - {{CNT_W{1'b0}}, pop_i};
    if (sum > CntMax) sum = CntMax;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= sum[CNT_W-1:0];
  end

  assign nonempty_o = (cnt_q != '0);
endmodule

// File: rtl/sbm_addr_fsm.sv
module sbm_addr_fsm
  import split_bus_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic data_idle_i,
  input  logic bg_ni,
  input  logic abb_ni,
  input  logic aack_ni,
  input  logic artry_ni,
  output logic br_no,
  output logic ts_no,
  output logic ts_oe_o,
  output logic abb_no,
  output logic abb_oe_o,
  output logic pop_o,
  output logic requeue_o,
  output logic data_go_o
);
  addr_st_e st_q, st_d;
  logic     rty_q, rty_d;

  always_comb begin
    st_d  = st_q;
    rty_d = rty_q;
    unique case (st_q)
      A_IDLE: if (pend_i && data_idle_i) st_d = A_REQ;
      A_REQ:  if (!bg_ni && abb_ni) st_d = A_TS;
      A_TS, A_BUSY: begin
        if (!aack_ni) begin
          st_d  = A_REL;
          rty_d = !artry_ni;
        end else begin
          st_d = A_BUSY;
        end
      end
      A_REL: begin
        st_d  = A_IDLE;
        rty_d = 1'b0;
      end
      default: st_d = A_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= A_IDLE;
      rty_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rty_q <= rty_d;
    end
  end

  // retry window covers the ack edge and the edge after it
  assign requeue_o = (st_q == A_REL) && (rty_q || !artry_ni);
  assign data_go_o = (st_q == A_REL) && !rty_q && artry_ni;
  assign pop_o     = (st_q == A_TS);

  assign br_no    = !((st_q == A_REQ) || (st_q == A_TS) || pend_i);
  assign ts_no    = !(st_q == A_TS);
  assign abb_oe_o = (st_q == A_TS) || (st_q == A_BUSY) || (st_q == A_REL);
  assign ts_oe_o  = abb_oe_o;
  assign abb_no   = !((st_q == A_TS) || (st_q == A_BUSY));
endmodule

// File: rtl/sbm_data_fsm.sv
module sbm_data_fsm
  import split_bus_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic dbg_ni,
  input  logic dbb_ni,
  input  logic ta_ni,
  output logic dbb_no,
  output logic dbb_oe_o,
  output logic done_o,
  output logic idle_o
);
  data_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      D_IDLE: if (go_i) st_d = D_WAIT;
      D_WAIT: if (!dbg_ni && dbb_ni) st_d = D_BUSY;
      D_BUSY: if (!ta_ni) st_d = D_REL;
      D_REL:  st_d = D_IDLE;
      default: st_d = D_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= D_IDLE;
    else         st_q <= st_d;
  end

  assign dbb_oe_o = (st_q == D_BUSY) || (st_q == D_REL);
  assign dbb_no   = !(st_q == D_BUSY);
  assign done_o   = (st_q == D_REL);
  assign idle_o   = (st_q == D_IDLE);
endmodule

// File: rtl/split_bus_master.sv
module split_bus_master #(
  parameter int CNT_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic done_o,
  output logic br_no,
  input  logic bg_ni,
  input  logic abb_ni,
  output logic abb_no,
  output logic abb_oe_o,
  output logic ts_no,
  output logic ts_oe_o,
  input  logic aack_ni,
  input  logic artry_ni,
  input  logic dbg_ni,
  input  logic dbb_ni,
  output logic dbb_no,
  output logic dbb_oe_o,
  input  logic ta_ni
);
  logic pend, pop, requeue, data_go, data_idle;

  sbm_req_queue #(.CNT_W(CNT_W)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (req_i),
    .requeue_i  (requeue),
    .pop_i      (pop),
    .nonempty_o (pend)
  );

  sbm_addr_fsm u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (pend),
    .data_idle_i (data_idle),
    .bg_ni       (bg_ni),
    .abb_ni      (abb_ni),
    .aack_ni     (aack_ni),
    .artry_ni    (artry_ni),
    .br_no       (br_no),
    .ts_no       (ts_no),
    .ts_oe_o     (ts_oe_o),
    .abb_no      (abb_no),
    .abb_oe_o    (abb_oe_o),
    .pop_o       (pop),
    .requeue_o   (requeue),
    .data_go_o   (data_go)
  );

  sbm_data_fsm u_data (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (data_go),
    .dbg_ni   (dbg_ni),
    .dbb_ni   (dbb_ni),
    .ta_ni    (ta_ni),
    .dbb_no   (dbb_no),
    .dbb_oe_o (dbb_oe_o),
    .done_o   (done_o),
    .idle_o   (data_idle)
  );
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic done_o,
  input logic br_no,
  input logic bg_ni,
  input logic abb_ni,
  input logic abb_no,
  input logic abb_oe_o,
  input logic ts_no,
  input logic ts_oe_o,
  input logic aack_ni,
  input logic dbg_ni,
  input logic dbb_ni,
  input logic dbb_no,
  input logic dbb_oe_o,
  input logic ta_ni
);
  a_r1_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abb_oe_o |-> ts_no);
  a_r2_br_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts_no |-> !br_no);
  a_r3_start_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts_no |-> $past(!bg_ni && abb_ni));
  a_r4_ts_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts_no |=> ts_no);
  a_r4_ts_drives_abb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts_no |-> (abb_oe_o && ts_oe_o && !abb_no));
  a_r5_abb_high_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abb_oe_o && !abb_no && !aack_ni) |=> (abb_oe_o && abb_no));
  a_r5_abb_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abb_oe_o && abb_no) |=> !abb_oe_o);
  a_r7_data_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbb_oe_o) |-> $past(!dbg_ni && dbb_ni));
  a_r8_dbb_high_on_ta: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbb_oe_o && !dbb_no && !ta_ni) |=> (dbb_oe_o && dbb_no));
  a_r8_dbb_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbb_oe_o && dbb_no) |=> !dbb_oe_o);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts_no |-> !dbb_oe_o);
endmodule

bind split_bus_master sbm_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .done_o   (done_o),
  .br_no    (br_no),
  .bg_ni    (bg_ni),
  .abb_ni   (abb_ni),
  .abb_no   (abb_no),
  .abb_oe_o (abb_oe_o),
  .ts_no    (ts_no),
  .ts_oe_o  (ts_oe_o),
  .aack_ni  (aack_ni),
  .dbg_ni   (dbg_ni),
  .dbb_ni   (dbb_ni),
  .dbb_no   (dbb_no),
  .dbb_oe_o (dbb_oe_o),
  .ta_ni    (ta_ni)
);

// File: tb/sim_split_bus_master.sv
`timescale 1ns/1ps
module sim_split_bus_master;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic bg_ni = 1'b0, abb_ni = 1'b1, aack_ni = 1'b1, artry_ni = 1'b1;
  logic dbg_ni = 1'b0, dbb_ni = 1'b1, ta_ni = 1'b1;
  logic done_o, br_no, abb_no, abb_oe_o, ts_no, ts_oe_o, dbb_no, dbb_oe_o;

  always #2.5 clk_i = ~clk_i;

  split_bus_master u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .done_o(done_o),
    .br_no(br_no), .bg_ni(bg_ni), .abb_ni(abb_ni), .abb_no(abb_no),
    .abb_oe_o(abb_oe_o), .ts_no(ts_no), .ts_oe_o(ts_oe_o),
    .aack_ni(aack_ni), .artry_ni(artry_ni), .dbg_ni(dbg_ni), .dbb_ni(dbb_ni),
    .dbb_no(dbb_no), .dbb_oe_o(dbb_oe_o), .ta_ni(ta_ni)
  );

  int n_chk = 0, n_fail = 0;
  bit tb_end = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // scoreboard
  int exp_q[$];
  int next_id = 0, done_seq = 0;
  int ts_cnt = 0, rty_cnt = 0, dstart_cnt = 0, pend = 0;

  // responder knobs
  int aack_dly = 0, ta_dly = 0, rty_mode = 0;

  task automatic launch();
    exp_q.push_back(next_id);
    next_id++;
    @(negedge clk_i); #1 req_i = 1'b1;
    @(negedge clk_i); #1 req_i = 1'b0;
  endtask

  task automatic wait_quiet(input string tag);
    int n = 0;
    while (!(exp_q.size() == 0 && !abb_oe_o && !dbb_oe_o && br_no) && n < 400) begin
      @(negedge clk_i); n++;
    end
    chk(n < 400, tag, n, 400);
  endtask

  // monitor and bus responder
  bit p_ts, p_abb_lo, p_abb_hi, p_dbb_lo, p_dbb_hi, p_done, after_ts;
  bit addr_ok, rty_flag, late_rty, a_arm, t_arm;
  int a_cnt, t_cnt;

  always @(negedge clk_i) begin
    if (rst_ni && !tb_end) begin
      bit abb_lo, abb_hi, dbb_lo, dbb_hi;
      abb_lo = abb_oe_o && !abb_no;
      abb_hi = abb_oe_o && abb_no;
      dbb_lo = dbb_oe_o && !dbb_no;
      dbb_hi = dbb_oe_o && dbb_no;
      if (req_i) pend++;
      if (!ts_no) begin
        ts_cnt++;
        chk(!bg_ni && abb_ni, "R3 start gate", {bg_ni, abb_ni}, 1);
        chk(abb_lo && ts_oe_o && !p_ts, "R4 start drive", {abb_oe_o, abb_no, ts_oe_o}, 3'b101);
        chk(!br_no, "R2 br held at start", br_no, 0);
        chk(!dbb_oe_o && !addr_ok, "R11 no overlap", dbb_oe_o, 0);
        pend--;
        after_ts = 1'b1;
      end else if (after_ts) begin
        chk(br_no == (pend == 0), "R10 br after start", br_no, pend == 0);
        after_ts = 1'b0;
      end
      if (p_abb_lo) begin
        if (aack_ni) chk(abb_lo, "R4 abb held", {abb_oe_o, abb_no}, 2'b10);
        else         chk(abb_hi, "R5 abb high", {abb_oe_o, abb_no}, 2'b11);
      end
      if (p_abb_hi) begin
        chk(!abb_oe_o, "R5 abb release", abb_oe_o, 0);
        if (rty_flag) begin pend++; rty_cnt++; rty_flag = 1'b0; end
        else addr_ok = 1'b1;
      end
      if (dbb_lo && !p_dbb_lo) begin
        dstart_cnt++;
        chk(!dbg_ni && dbb_ni && addr_ok, "R7 data start", {dbg_ni, dbb_ni, addr_ok}, 3'b011);
        addr_ok = 1'b0;
      end
      if (p_dbb_lo) begin
        if (ta_ni) chk(dbb_lo, "R8 dbb held", {dbb_oe_o, dbb_no}, 2'b10);
        else       chk(dbb_hi, "R8 dbb high", {dbb_oe_o, dbb_no}, 2'b11);
      end
      if (p_dbb_hi) chk(!dbb_oe_o, "R8 dbb release", dbb_oe_o, 0);
      if (done_o) begin
        chk(!ta_ni && p_dbb_lo && !p_done, "R9 done timing", {ta_ni, p_dbb_lo, p_done}, 3'b010);
        if (exp_q.size() == 0) chk(1'b0, "R9 extra done", done_seq, -1);
        else begin
          int id;
          id = exp_q.pop_front();
          chk(id == done_seq, "R9 done order", done_seq, id);
        end
        done_seq++;
      end else if (p_dbb_lo && !ta_ni) begin
        chk(1'b0, "R9 missing done", 0, 1);
      end
      p_ts = !ts_no; p_abb_lo = abb_lo; p_abb_hi = abb_hi;
      p_dbb_lo = dbb_lo; p_dbb_hi = dbb_hi; p_done = done_o;

      // responder
      aack_ni = 1'b1; artry_ni = 1'b1; ta_ni = 1'b1;
      if (late_rty) begin artry_ni = 1'b0; late_rty = 1'b0; rty_flag = 1'b1; end
      if (!ts_no) begin a_arm = 1'b1; a_cnt = aack_dly; end
      if (a_arm) begin
        if (a_cnt == 0) begin
          aack_ni = 1'b0; a_arm = 1'b0;
          if (rty_mode == 1) begin artry_ni = 1'b0; rty_flag = 1'b1; end
          if (rty_mode == 2) late_rty = 1'b1;
          rty_mode = 0;
        end else a_cnt--;
      end
      if (dbb_lo && !t_arm && !(p_dbb_lo && t_cnt < 0)) begin
        if (!ta_fired) begin t_arm = 1'b1; t_cnt = ta_dly; end
      end
      if (t_arm) begin
        if (t_cnt == 0) begin ta_ni = 1'b0; t_arm = 1'b0; ta_fired = 1'b1; end
        else t_cnt--;
      end
      if (!dbb_oe_o) ta_fired = 1'b0;
    end
  end
  bit ta_fired = 1'b0;

  initial begin
    repeat (3) @(negedge clk_i);
    chk(br_no && ts_no && abb_no && dbb_no && !ts_oe_o && !abb_oe_o && !dbb_oe_o && !done_o,
        "R1 reset state", {br_no, ts_no, abb_oe_o, dbb_oe_o, done_o}, 5'b11000);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(br_no && ts_no && !abb_oe_o && !dbb_oe_o && !done_o, "R1 after reset",
        {br_no, ts_no, abb_oe_o, dbb_oe_o}, 4'b1100);

    // plain transfer, grants parked
    launch();
    wait_quiet("R9 single transfer");
    chk(ts_cnt == 1 && dstart_cnt == 1, "R9 one tenure each", ts_cnt, 1);

    // other master holds address-busy while grant is present
    #1 abb_ni = 1'b0;
    launch();
    repeat (6) @(negedge clk_i);
    chk(ts_cnt == 1, "R3 blocked by abb", ts_cnt, 1);
    chk(!br_no, "R2 br while waiting", br_no, 0);
    #1 abb_ni = 1'b1;
    wait_quiet("R3 resumes");

    // late address grant, slow address ack
    #1 bg_ni = 1'b1; aack_dly = 3;
    launch();
    repeat (5) @(negedge clk_i);
    chk(ts_cnt == 2 && !br_no, "R2 waits for grant", ts_cnt, 2);
    #1 bg_ni = 1'b0;
    wait_quiet("R4 slow ack");
    aack_dly = 0;

    // retry with the ack
    rty_mode = 1;
    launch();
    wait_quiet("R6 retry at ack");
    chk(ts_cnt == 5 && rty_cnt == 1, "R6 restart after retry", ts_cnt, 5);
    chk(dstart_cnt == 4, "R6 no data for retried", dstart_cnt, 4);

    // retry one cycle after the ack
    rty_mode = 2; aack_dly = 1;
    launch();
    wait_quiet("R6 late retry");
    chk(ts_cnt == 7 && rty_cnt == 2, "R6 late restart", ts_cnt, 7);
    chk(dstart_cnt == 5, "R6 late no data", dstart_cnt, 5);
    aack_dly = 0;

    // data grant late, other master holds data-busy, slow ta
    #1 dbg_ni = 1'b1; dbb_ni = 1'b0; ta_dly = 4;
    launch();
    repeat (8) @(negedge clk_i);
    chk(!dbb_oe_o && dstart_cnt == 5, "R7 waits for data grant", dstart_cnt, 5);
    #1 dbg_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(!dbb_oe_o && done_seq == 5, "R7 waits for dbb idle", dbb_oe_o, 0);
    #1 dbb_ni = 1'b1;
    wait_quiet("R8 slow ta");
    ta_dly = 0;

    // three queued requests
    #1 bg_ni = 1'b1;
    launch(); launch(); launch();
    repeat (2) @(negedge clk_i);
    #1 bg_ni = 1'b0;
    wait_quiet("R10 queued burst");
    chk(done_seq == 9 && ts_cnt == 11, "R9 burst count", done_seq, 9);
    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

    tb_end = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!tb_end) begin
      tb_end = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule